// File: doc/BRIEF.md
# Disc Controller Run-State Sequencer

This block keeps the top-level run state of a controller that serves several disc drives. At any moment the controller is idle (polling its drives), waiting (holding in a loop until a command arrives) or busy (executing a command). The block takes single-cycle event pulses: a command arrived, the End command finished, any other command finished, and a drive finished a seek. It also takes a level that says interrupts are enabled and one attention bit per drive. From these inputs it produces the current state, a one-cycle strobe that tells the command engine to start, and a one-cycle attention-poll strobe with the index of the drive chosen.

Two down-counters guard the loops. One limits how long the controller waits for a command. The other limits how long a busy command may go on without finishing, for example while it waits for parameters. A command that arrives while the controller is busy is held in a one-deep slot. Every time the controller enters the wait or idle state, it looks at that slot first. On entry to idle it also looks at drive attention, so no work is lost across a state change.

Top module: `disc_run_seq`

## Requirements
- R1: `state_o` encodes idle as 0, wait as 1 and busy as 2, and never shows 3. A synchronous reset `rst` forces idle, drops both strobes, sets `poll_idx_o` to 0, clears both timers and empties the held-command slot.
- R2: `cmd_rx_i` in idle or wait makes the state busy at the next clock edge. At that edge `start_o` rises for exactly one cycle.
- R3: In busy, `cmd_done_i` without `end_done_i` makes the state wait at the next edge.
- R4: In busy, `end_done_i` makes the state idle at the next edge. It wins over `cmd_done_i` when both are given in the same cycle.
- R5: In wait with no command, the state returns to idle after exactly CMD_TMO+1 cycles in wait. A command given on that last cycle still makes the state busy.
- R6: In busy with no finish pulse, the state goes to idle after exactly PRM_TMO+1 cycles in busy. A finish pulse on that last cycle wins over the timeout.
- R7: `cmd_rx_i` during busy is held. In the first cycle after the controller enters wait or idle, the held command makes the state busy and raises `start_o`. Reset discards a held command.
- R8: In idle with `int_en_i` high, a `seek_done_i` pulse or any set `attn_i` bit makes the state wait. With `int_en_i` low the state stays idle. A command in the same cycle wins: the state goes to busy and no poll occurs.
- R9: When attention causes the idle-to-wait move, `poll_o` pulses for one cycle. `poll_idx_o` then gives the first set `attn_i` bit, searching upward with wraparound from one past the last polled index. After reset the search starts at bit 0. At all other times `poll_idx_o` keeps its value. A seek completion alone gives no poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_rx_i | input | 1 | Pulse: a command has arrived |
| end_done_i | input | 1 | Pulse: the End command finished |
| cmd_done_i | input | 1 | Pulse: a command other than End finished |
| seek_done_i | input | 1 | Pulse: a drive finished a seek |
| int_en_i | input | 1 | Level: interrupts are enabled |
| attn_i | input | NUM_DRIVES | Attention bit of each drive |
| state_o | output | 2 | Run state: 0 idle, 1 wait, 2 busy |
| start_o | output | 1 | One-cycle strobe to start a command |
| poll_o | output | 1 | One-cycle attention-poll strobe |
| poll_idx_o | output | $clog2(NUM_DRIVES) | Index of the drive chosen by the poll |

## Verification
All outputs are registered. A pulse presented in one cycle therefore shows its effect at the very next rising edge, and a held command shows its effect one edge after the state change that uncovers it. The bench drives inputs on the falling edge and samples one falling edge later, so each check lands in the cycle just after the deciding edge. For the timeouts, the bench counts whole cycles from the edge that entered the state. It expects the state unchanged through CMD_TMO or PRM_TMO further samples and changed on the next one.

// File: rtl/disc_run_pkg.sv
package disc_run_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BUSY = 2'd2
    } run_st_e;

endpackage

// File: rtl/disc_rr_pick.sv
// Cyclic first-set search starting one past the last serviced position.
module disc_rr_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        // walk from farthest to nearest so the nearest request wins
        for (int k = N; k >= 1; k--) begin
            automatic int p = (int'(last_i) + k) % N;
            if (req_i[p]) begin
                hit_o = 1'b1;
                idx_o = IW'(p);
            end
        end
    end

endmodule

// File: rtl/disc_down_timer.sv
// Reloadable down-counter that stops at zero.
module disc_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] reload_i,
    input  logic         dec_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = reload_i;
        else if (dec_i && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/disc_run_seq.sv
module disc_run_seq
    import disc_run_pkg::*;
#(
    parameter int NUM_DRIVES = 8,
    parameter int CMD_TMO    = 200,
    parameter int PRM_TMO    = 100,
    localparam int IDX_W     = $clog2(NUM_DRIVES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_rx_i,
    input  logic                  end_done_i,
    input  logic                  cmd_done_i,
    input  logic                  seek_done_i,
    input  logic                  int_en_i,
    input  logic [NUM_DRIVES-1:0] attn_i,
    output logic [1:0]            state_o,
    output logic                  start_o,
    output logic                  poll_o,
    output logic [IDX_W-1:0]      poll_idx_o
);

    localparam int TMO_MAX = (CMD_TMO > PRM_TMO) ? CMD_TMO : PRM_TMO;
    localparam int TMO_W   = $clog2(TMO_MAX + 1);

    typedef struct packed {
        run_st_e          state;
        logic             pend;
        logic             start;
        logic             poll;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             pick_hit;
    logic [IDX_W-1:0] pick_idx;
    logic             cmd_zero, prm_zero;
    logic             cmd_load, prm_load;
    logic             take_cmd;

    disc_rr_pick #(.N(NUM_DRIVES), .IW(IDX_W)) i_pick (
        .req_i  (attn_i),
        .last_i (seq_q.last),
        .hit_o  (pick_hit),
        .idx_o  (pick_idx)
    );

    assign take_cmd = cmd_rx_i || seq_q.pend;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        seq_d.poll  = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (take_cmd) begin
                    seq_d.state = ST_BUSY;
                    seq_d.start = 1'b1;
                    seq_d.pend  = 1'b0;
                end else if (int_en_i && (seek_done_i || pick_hit)) begin
                    seq_d.state = ST_WAIT;
                    if (pick_hit) begin
                        seq_d.poll = 1'b1;
                        seq_d.idx  = pick_idx;
                        seq_d.last = pick_idx;
                    end
                end
            end
            ST_WAIT: begin
                if (take_cmd) begin
                    seq_d.state = ST_BUSY;
                    seq_d.start = 1'b1;
                    seq_d.pend  = 1'b0;
                end else if (cmd_zero) begin
                    seq_d.state = ST_IDLE;
                end
            end
            ST_BUSY: begin
                if (cmd_rx_i)
                    seq_d.pend = 1'b1;
                if (end_done_i)
                    seq_d.state = ST_IDLE;
                else if (cmd_done_i)
                    seq_d.state = ST_WAIT;
                else if (prm_zero)
                    seq_d.state = ST_IDLE;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state <= ST_IDLE;
            seq_q.pend  <= 1'b0;
            seq_q.start <= 1'b0;
            seq_q.poll  <= 1'b0;
            seq_q.idx   <= '0;
            seq_q.last  <= IDX_W'(NUM_DRIVES - 1);
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_load = (seq_d.state == ST_WAIT) && (seq_q.state != ST_WAIT);
    assign prm_load = (seq_d.state == ST_BUSY) && (seq_q.state != ST_BUSY);

    disc_down_timer #(.W(TMO_W)) i_cmd_tmr (
        .clk      (clk),
        .rst      (rst),
        .load_i   (cmd_load),
        .reload_i (TMO_W'(CMD_TMO)),
        .dec_i    (seq_q.state == ST_WAIT),
        .zero_o   (cmd_zero)
    );

    disc_down_timer #(.W(TMO_W)) i_prm_tmr (
        .clk      (clk),
        .rst      (rst),
        .load_i   (prm_load),
        .reload_i (TMO_W'(PRM_TMO)),
        .dec_i    (seq_q.state == ST_BUSY),
        .zero_o   (prm_zero)
    );

    assign state_o    = seq_q.state;
    assign start_o    = seq_q.start;
    assign poll_o     = seq_q.poll;
    assign poll_idx_o = seq_q.idx;

endmodule

// File: rtl/disc_run_seq_chk.sv
module disc_run_seq_chk #(
    parameter int NUM_DRIVES = 8,
    parameter int IDX_W      = $clog2(NUM_DRIVES)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_rx_i,
    input logic                  end_done_i,
    input logic                  cmd_done_i,
    input logic                  int_en_i,
    input logic [NUM_DRIVES-1:0] attn_i,
    input logic [1:0]            state_o,
    input logic                  start_o,
    input logic                  poll_o,
    input logic [IDX_W-1:0]      poll_idx_o
);

    localparam logic [1:0] S_IDLE = 2'd0;
    localparam logic [1:0] S_WAIT = 2'd1;
    localparam logic [1:0] S_BUSY = 2'd2;

    logic                  armed_q = 1'b0;
    logic [NUM_DRIVES-1:0] attn_prev_q = '0;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b1;
        attn_prev_q <= attn_i;
    end

    a_r1_legal_state: assert property (@(posedge clk) disable iff (rst || !armed_q)
        state_o != 2'b11);

    a_r2_cmd_starts: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (cmd_rx_i && (state_o == S_IDLE || state_o == S_WAIT))
        |=> (state_o == S_BUSY && start_o));

    a_r2_start_single: assert property (@(posedge clk) disable iff (rst || !armed_q)
        start_o |=> !start_o);

    a_r3_other_to_wait: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (state_o == S_BUSY && cmd_done_i && !end_done_i) |=> (state_o == S_WAIT));

    a_r4_end_to_idle: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (state_o == S_BUSY && end_done_i) |=> (state_o == S_IDLE));

    a_r8_poll_needs_enable: assert property (@(posedge clk) disable iff (rst || !armed_q)
        poll_o |-> (state_o == S_WAIT && $past(int_en_i) && attn_prev_q[poll_idx_o]));

    a_r9_poll_not_with_start: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !(poll_o && start_o));

endmodule

bind disc_run_seq disc_run_seq_chk #(.NUM_DRIVES(NUM_DRIVES), .IDX_W(IDX_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_rx_i   (cmd_rx_i),
    .end_done_i (end_done_i),
    .cmd_done_i (cmd_done_i),
    .int_en_i   (int_en_i),
    .attn_i     (attn_i),
    .state_o    (state_o),
    .start_o    (start_o),
    .poll_o     (poll_o),
    .poll_idx_o (poll_idx_o)
);

// File: tb/test_disc_run_seq.sv
module test_disc_run_seq;

    localparam int CLK_P = 10;
    localparam int ND    = 8;
    localparam int CTMO  = 6;
    localparam int PTMO  = 4;
    localparam int NVEC  = 25;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_rx = 1'b0, end_done = 1'b0, cmd_done = 1'b0, seek_done = 1'b0, int_en = 1'b0;
    logic [7:0] attn = '0;
    logic [1:0] state;
    logic       start, poll;
    logic [2:0] pidx;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    disc_run_seq #(.NUM_DRIVES(ND), .CMD_TMO(CTMO), .PRM_TMO(PTMO)) i_disc_run_seq (
        .clk(clk), .rst(rst), .cmd_rx_i(cmd_rx), .end_done_i(end_done),
        .cmd_done_i(cmd_done), .seek_done_i(seek_done), .int_en_i(int_en),
        .attn_i(attn), .state_o(state), .start_o(start), .poll_o(poll), .poll_idx_o(pidx)
    );

    // stimulus: cmd, end, other, seek, ie, attn | expected: state, start, poll, idx, tag
    typedef struct packed {
        logic       c, e, o, s, ie;
        logic [7:0] a;
        logic [1:0] st;
        logic       sp, pl;
        logic [2:0] ix;
        logic [3:0] rq;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0,3'd0, 4'd2},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00, 2'd1,1'b0,1'b0,3'd0, 4'd3},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0,3'd0, 4'd2},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 2'd2,1'b0,1'b0,3'd0, 4'd7},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 2'd0,1'b0,1'b0,3'd0, 4'd4},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0,3'd0, 4'd7},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 2'd0,1'b0,1'b0,3'd0, 4'd4},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h04, 2'd0,1'b0,1'b0,3'd0, 4'd8},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'h04, 2'd1,1'b0,1'b1,3'd2, 4'd9},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0,3'd2, 4'd2},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 2'd0,1'b0,1'b0,3'd2, 4'd4},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'h05, 2'd1,1'b0,1'b1,3'd0, 4'd9},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0,3'd0, 4'd2},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 2'd0,1'b0,1'b0,3'd0, 4'd4},
        '{1'b0,1'b0,1'b0,1'b1,1'b1,8'h00, 2'd1,1'b0,1'b0,3'd0, 4'd8},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0,3'd0, 4'd2},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 2'd0,1'b0,1'b0,3'd0, 4'd4},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,8'h80, 2'd2,1'b1,1'b0,3'd0, 4'd8},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 2'd0,1'b0,1'b0,3'd0, 4'd4},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0,3'd0, 4'd2},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00, 2'd0,1'b0,1'b0,3'd0, 4'd4},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0,3'd0, 4'd2},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,8'h00, 2'd1,1'b0,1'b0,3'd0, 4'd7},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 2'd2,1'b1,1'b0,3'd0, 4'd7},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 2'd0,1'b0,1'b0,3'd0, 4'd4}
    };

    task automatic step(input logic c, e, o, s, ie, input logic [7:0] a);
        cmd_rx = c; end_done = e; cmd_done = o; seek_done = s; int_en = ie; attn = a;
        @(posedge clk);
        @(negedge clk);
        cmd_rx = 1'b0; end_done = 1'b0; cmd_done = 1'b0; seek_done = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [1:0] est,
                              input logic esp, epl, input logic [2:0] eix);
        checks++;
        if (state !== est || start !== esp || poll !== epl || pidx !== eix) begin
            fails++;
            $display("FAIL %s actual state=%0d start=%b poll=%b idx=%0d expected state=%0d start=%b poll=%b idx=%0d",
                     req, state, start, poll, pidx, est, esp, epl, eix);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual cycles=5000 expected fewer");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        // R1: reset state
        rst = 1'b1;
        repeat (2) @(negedge clk);
        expect_out("R1 reset", 2'd0, 1'b0, 1'b0, 3'd0);
        rst = 1'b0;

        // table walk: R2 R3 R4 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].c, VEC[i].e, VEC[i].o, VEC[i].s, VEC[i].ie, VEC[i].a);
            expect_out($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].st, VEC[i].sp, VEC[i].pl, VEC[i].ix);
        end

        // R5: wait timeout after CTMO+1 cycles
        step(1,0,0,0,0,8'h00);
        step(0,0,1,0,0,8'h00);
        expect_out("R5 enter wait", 2'd1, 1'b0, 1'b0, 3'd0);
        for (int k = 0; k < CTMO; k++) begin
            step(0,0,0,0,0,8'h00);
            expect_out("R5 still wait", 2'd1, 1'b0, 1'b0, 3'd0);
        end
        step(0,0,0,0,0,8'h00);
        expect_out("R5 timed out", 2'd0, 1'b0, 1'b0, 3'd0);

        // R5: command on final wait cycle wins
        step(1,0,0,0,0,8'h00);
        step(0,0,1,0,0,8'h00);
        for (int k = 0; k < CTMO; k++) step(0,0,0,0,0,8'h00);
        step(1,0,0,0,0,8'h00);
        expect_out("R5 late cmd", 2'd2, 1'b1, 1'b0, 3'd0);

        // R6: busy timeout after PTMO+1 cycles
        for (int k = 0; k < PTMO; k++) begin
            step(0,0,0,0,0,8'h00);
            expect_out("R6 still busy", 2'd2, 1'b0, 1'b0, 3'd0);
        end
        step(0,0,0,0,0,8'h00);
        expect_out("R6 timed out", 2'd0, 1'b0, 1'b0, 3'd0);

        // R6: finish on final busy cycle wins
        step(1,0,0,0,0,8'h00);
        for (int k = 0; k < PTMO; k++) step(0,0,0,0,0,8'h00);
        step(0,0,1,0,0,8'h00);
        expect_out("R6 late done", 2'd1, 1'b0, 1'b0, 3'd0);

        // R1 R7: reset mid-busy discards held command
        step(1,0,0,0,0,8'h00);
        step(1,0,0,0,0,8'h00);
        rst = 1'b1;
        step(0,0,0,0,0,8'h00);
        expect_out("R1 reset in busy", 2'd0, 1'b0, 1'b0, 3'd0);
        rst = 1'b0;
        step(0,0,0,0,0,8'h00);
        expect_out("R7 held cmd dropped", 2'd0, 1'b0, 1'b0, 3'd0);

        // R9: search restarts at 0 after reset
        step(0,0,0,0,1,8'h0A);
        expect_out("R9 rr after reset", 2'd1, 1'b0, 1'b1, 3'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule